// File: doc/BRIEF.md
# Start-up Reset and Calibration Sequencer

This block decides when the chip leaves reset after power is applied. It watches a digital supply-good indication, flags that report whether the reference clock and the transmit clock are running, an external reset request, and a done handshake from the calibration engine. While the supply is low, or while the external reset is held, it keeps the control logic and the register set in reset. After the supply becomes good it waits a fixed settling time, counted in cycles of its timebase clock. Once that time has passed it releases the global reset and asks the analog front end to calibrate its transmit and receive paths.

Calibration is requested only while both clocks are present. If a clock goes missing during calibration, the attempt is abandoned and the block waits for the clocks again. If the done handshake does not arrive within a cycle budget, the block raises a sticky timeout flag and tries again. Each reset cause also sets a sticky status flag. Host software can read that flag and clear it with a write-one-to-clear strobe. The ready output tells the rest of the chip that start-up is complete.

Top module: `startup_sequencer`

## Requirements
- R1: In any cycle in which `supply_ok` is sampled low, the block goes to its hold state at that clock edge. From the next cycle `sys_reset` is 1, and `cal_req` and `ready` are 0.
- R2: After the first edge that samples `supply_ok` high with `ext_reset` low, `sys_reset` stays 1 for exactly `SETTLE_CYCLES` more cycles and is then released.
- R3: Once `sys_reset` is released, `cal_req` rises only on the edge after an edge that samples both `refclk_ok` and `txclk_ok` high. With either flag low, the block waits and `cal_req` stays 0.
- R4: When `cal_done` is sampled high while `cal_req` is 1, `ready` becomes 1 and `cal_req` becomes 0 at that edge. `ready` is 1 only after such a completion and until the next reset cause.
- R5: If `cal_done` has not been seen after `CAL_LIMIT` cycles of `cal_req`, `cal_req` drops for one cycle and `cal_timeout` is set. Calibration is then requested again if both clocks are still present.
- R6: If either clock flag is sampled low during calibration with no `cal_done`, `cal_req` drops at that edge without setting `cal_timeout`. The request resumes one cycle after both flags are high again.
- R7: Asserting `ext_reset` from any state has the same effect as a low supply. Releasing it starts the full settle-and-calibrate sequence again.
- R8: `reset_latched` is set by every cycle that has a reset cause (supply low or `ext_reset` high). It stays set until a `clr_reset_flag` strobe in a cycle with no reset cause clears it on the next edge. A strobe during a reset cause leaves it set.
- R9: `cal_timeout` stays set until either a `clr_timeout_flag` strobe or a reset cause clears it on the next edge.
- R10: Once `ready` is 1, a loss of either clock flag has no effect on `ready`, `cal_req` or `sys_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| supply_ok | input | 1 | Supply above the start threshold; low acts as synchronous reset |
| ext_reset | input | 1 | External reset request, active high |
| refclk_ok | input | 1 | Reference clock detected |
| txclk_ok | input | 1 | Transmit clock detected |
| cal_done | input | 1 | Calibration engine reports completion |
| clr_reset_flag | input | 1 | Write-one-to-clear strobe for `reset_latched` |
| clr_timeout_flag | input | 1 | Write-one-to-clear strobe for `cal_timeout` |
| sys_reset | output | 1 | Global reset to control logic and registers |
| cal_req | output | 1 | Calibration request to the analog front end |
| ready | output | 1 | Start-up sequence complete |
| reset_latched | output | 1 | Sticky record of a reset event |
| cal_timeout | output | 1 | Sticky record of a calibration attempt that timed out |

## Verification
The bench times every edge of `sys_reset`, `cal_req`, `ready` and `cal_timeout` to the exact cycle. A settle counter that is off by one would therefore show up as a misplaced release, and a request raised on one clock alone would show up as an unexpected `cal_req` edge. It lets calibration time out and checks that the retry follows after exactly one idle cycle. It removes a clock during a retry and confirms that no timeout is recorded for the abort. It also removes a clock after `ready`, where a design that aborted there would drop `ready`. It sends a clear strobe while the external reset is held, which a clear-wins flag would lose. It then cuts the supply while the timeout flag is set, to catch a flag that survives reset.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD     = 3'd0,
        ST_SETTLE   = 3'd1,
        ST_WAIT_CLK = 3'd2,
        ST_CAL      = 3'd3,
        ST_READY    = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic sys_reset;
        logic cal_req;
        logic ready;
    } seq_out_t;

    typedef struct packed {
        logic settle_done;
        logic cal_expired;
    } timer_flags_t;

    localparam int unsigned FLAG_RESET   = 0;
    localparam int unsigned FLAG_TIMEOUT = 1;
    localparam int unsigned NUM_FLAGS    = 2;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic seq_out_t decode_outputs(input seq_state_e s);
        seq_out_t o;
        o.sys_reset = (s == ST_HOLD) || (s == ST_SETTLE);
        o.cal_req   = (s == ST_CAL);
        o.ready     = (s == ST_READY);
        return o;
    endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             clear_i,
    output logic [WIDTH-1:0] count_o
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != {WIDTH{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // set has priority over a simultaneous clear (R8, R9)
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (1'b0)
        set_i |=> flag_o);
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (set_i)
        clr_i |=> !flag_o);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import startup_seq_pkg::*;
(
    input  logic         clk,
    input  logic         hold_i,
    input  logic         clocks_ok_i,
    input  logic         cal_done_i,
    input  timer_flags_t tmr_i,
    output seq_state_e   state_o,
    output logic         enter_o,
    output logic         timeout_evt_o
);

    seq_state_e state_q, state_d;
    logic       timeout_evt;

    always_comb begin
        state_d     = state_q;
        timeout_evt = 1'b0;
        if (hold_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:     state_d = ST_SETTLE;
                ST_SETTLE:   if (tmr_i.settle_done) state_d = ST_WAIT_CLK;
                ST_WAIT_CLK: if (clocks_ok_i) state_d = ST_CAL;
                ST_CAL: begin
                    if (cal_done_i) begin
                        state_d = ST_READY;
                    end else if (!clocks_ok_i) begin
                        state_d = ST_WAIT_CLK;
                    end else if (tmr_i.cal_expired) begin
                        state_d     = ST_WAIT_CLK;
                        timeout_evt = 1'b1;
                    end
                end
                ST_READY:    state_d = ST_READY;
                default:     state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign state_o       = state_q;
    assign enter_o       = (state_d != state_q);
    assign timeout_evt_o = timeout_evt;

    // a reset cause always lands in the hold state (R1, R7)
    assert_hold_entry_R7: assert property (@(posedge clk) disable iff (1'b0)
        hold_i |=> state_q == ST_HOLD);
    // ready is sticky until a reset cause (R10)
    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (hold_i)
        state_q == ST_READY |=> state_q == ST_READY);

endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import startup_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 10000,
    parameter int unsigned CAL_LIMIT     = 20000
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic ext_reset,
    input  logic refclk_ok,
    input  logic txclk_ok,
    input  logic cal_done,
    input  logic clr_reset_flag,
    input  logic clr_timeout_flag,
    output logic sys_reset,
    output logic cal_req,
    output logic ready,
    output logic reset_latched,
    output logic cal_timeout
);

    localparam int unsigned SPAN  = max2(SETTLE_CYCLES, CAL_LIMIT);
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CAL_LAST    = CNT_W'(CAL_LIMIT - 1);

    logic             hold_rst;
    logic             clocks_ok;
    logic             enter;
    logic             timeout_evt;
    logic [CNT_W-1:0] cnt;
    timer_flags_t     tmr;
    seq_state_e       state;
    seq_out_t         outs;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_val;

    assign hold_rst  = !supply_ok || ext_reset;
    assign clocks_ok = refclk_ok && txclk_ok;

    seq_counter #(.WIDTH(CNT_W)) u_counter (
        .clk     (clk),
        .clear_i (enter),
        .count_o (cnt)
    );

    assign tmr.settle_done = (cnt == SETTLE_LAST);
    assign tmr.cal_expired = (cnt == CAL_LAST);

    seq_fsm u_fsm (
        .clk           (clk),
        .hold_i        (hold_rst),
        .clocks_ok_i   (clocks_ok),
        .cal_done_i    (cal_done),
        .tmr_i         (tmr),
        .state_o       (state),
        .enter_o       (enter),
        .timeout_evt_o (timeout_evt)
    );

    assign outs      = decode_outputs(state);
    assign sys_reset = outs.sys_reset;
    assign cal_req   = outs.cal_req;
    assign ready     = outs.ready;

    assign flag_set[FLAG_RESET]   = hold_rst;
    assign flag_clr[FLAG_RESET]   = clr_reset_flag;
    assign flag_set[FLAG_TIMEOUT] = timeout_evt;
    assign flag_clr[FLAG_TIMEOUT] = clr_timeout_flag || hold_rst;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sticky_flag u_flag (
            .clk    (clk),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_val[g])
        );
    end

    assign reset_latched = flag_val[FLAG_RESET];
    assign cal_timeout   = flag_val[FLAG_TIMEOUT];

    assert_hold_outputs_R1: assert property (@(posedge clk) disable iff (1'b0)
        hold_rst |=> (sys_reset && !cal_req && !ready));
    assert_settle_release_R2: assert property (@(posedge clk) disable iff (hold_rst)
        $fell(sys_reset) |-> $past(tmr.settle_done));
    assert_cal_gate_R3: assert property (@(posedge clk) disable iff (hold_rst)
        $rose(cal_req) |-> $past(refclk_ok && txclk_ok));
    assert_ready_cause_R4: assert property (@(posedge clk) disable iff (hold_rst)
        $rose(ready) |-> $past(cal_done && cal_req));
    assert_timeout_drop_R5: assert property (@(posedge clk) disable iff (hold_rst)
        $rose(cal_timeout) |-> ($past(cal_req) && !cal_req));
    assert_clock_abort_R6: assert property (@(posedge clk) disable iff (hold_rst)
        (cal_req && !clocks_ok && !cal_done) |=> (!cal_req && !ready && $stable(cal_timeout)));

endmodule

// File: tb/tb_startup_sequencer.sv
module tb_startup_sequencer;

    localparam int unsigned S = 20;
    localparam int unsigned L = 30;

    localparam int EV_RST_RISE = 0, EV_RST_FALL = 1, EV_CR_RISE = 2, EV_CR_FALL = 3,
                   EV_RDY_RISE = 4, EV_RDY_FALL = 5, EV_TO_RISE = 6, EV_TO_FALL = 7;

    typedef struct { int kind; int cyc; string req; } exp_t;

    logic clk = 1'b0;
    logic supply_ok = 1'b0, ext_reset = 1'b0, refclk_ok = 1'b0, txclk_ok = 1'b0;
    logic cal_done = 1'b0, clr_reset_flag = 1'b0, clr_timeout_flag = 1'b0;
    logic sys_reset, cal_req, ready, reset_latched, cal_timeout;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    exp_t sb[$];
    logic p_rst = 1'b0, p_cr = 1'b0, p_rdy = 1'b0, p_to = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    startup_sequencer #(.SETTLE_CYCLES(S), .CAL_LIMIT(L)) dut (
        .clk(clk), .supply_ok(supply_ok), .ext_reset(ext_reset),
        .refclk_ok(refclk_ok), .txclk_ok(txclk_ok), .cal_done(cal_done),
        .clr_reset_flag(clr_reset_flag), .clr_timeout_flag(clr_timeout_flag),
        .sys_reset(sys_reset), .cal_req(cal_req), .ready(ready),
        .reset_latched(reset_latched), .cal_timeout(cal_timeout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int c, input string req);
        exp_t e;
        e.kind = kind; e.cyc = c; e.req = req;
        sb.push_back(e);
    endtask

    task automatic got(input int kind);
        exp_t e;
        if (sb.size() == 0) begin
            chk(1'b0, "R1..R10", $sformatf("unexpected event %0d at cycle %0d", kind, cyc), kind, -1);
        end else begin
            e = sb.pop_front();
            chk(e.kind == kind, e.req, "event kind", kind, e.kind);
            chk(e.cyc == cyc, e.req, $sformatf("cycle of event %0d", kind), cyc, e.cyc);
        end
    endtask

    // monitor: detects output edges and scores them against the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (!p_rst && sys_reset) got(EV_RST_RISE);
            if (p_rst && !sys_reset) got(EV_RST_FALL);
            if (!p_cr && cal_req)    got(EV_CR_RISE);
            if (p_cr && !cal_req)    got(EV_CR_FALL);
            if (!p_rdy && ready)     got(EV_RDY_RISE);
            if (p_rdy && !ready)     got(EV_RDY_FALL);
            if (!p_to && cal_timeout) got(EV_TO_RISE);
            if (p_to && !cal_timeout) got(EV_TO_FALL);
        end
        p_rst = sys_reset; p_cr = cal_req; p_rdy = ready; p_to = cal_timeout;
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not complete", cyc, 0);
        finish_run();
    end

    initial begin
        int c;
        tick(5);
        // R1 reset state with supply low
        chk(sys_reset == 1'b1, "R1", "sys_reset in hold", sys_reset, 1);
        chk(cal_req == 1'b0, "R1", "cal_req in hold", cal_req, 0);
        chk(ready == 1'b0, "R1", "ready in hold", ready, 0);
        chk(reset_latched == 1'b1, "R8", "reset_latched after power-up", reset_latched, 1);
        chk(cal_timeout == 1'b0, "R9", "cal_timeout in hold", cal_timeout, 0);
        mon_on = 1'b1;

        // R2 settle with clocks absent, then R3 gating
        c = cyc; supply_ok = 1'b1;
        expect_ev(EV_RST_FALL, c + 1 + S, "R2");
        tick(S + 6);
        chk(cal_req == 1'b0, "R3", "no request without clocks", cal_req, 0);
        refclk_ok = 1'b1;
        tick(4);
        chk(cal_req == 1'b0, "R3", "no request with refclk only", cal_req, 0);
        c = cyc; txclk_ok = 1'b1;
        expect_ev(EV_CR_RISE, c + 1, "R3");
        tick(5);
        // R4 completion
        c = cyc; cal_done = 1'b1;
        expect_ev(EV_CR_FALL, c + 1, "R4");
        expect_ev(EV_RDY_RISE, c + 1, "R4");
        tick(1); cal_done = 1'b0;
        tick(1);
        chk(ready == 1'b1, "R4", "ready after done", ready, 1);
        chk(reset_latched == 1'b1, "R8", "flag held without clear", reset_latched, 1);
        clr_reset_flag = 1'b1; tick(1); clr_reset_flag = 1'b0; tick(1);
        chk(reset_latched == 1'b0, "R8", "flag cleared by strobe", reset_latched, 0);

        // R10 clock loss in ready has no effect
        txclk_ok = 1'b0; refclk_ok = 1'b0; tick(6);
        chk(ready == 1'b1, "R10", "ready kept on clock loss", ready, 1);
        chk(cal_req == 1'b0, "R10", "no request on clock loss", cal_req, 0);
        refclk_ok = 1'b1; txclk_ok = 1'b1; tick(2);

        // R7 external reset, R8 clear during reset cause
        c = cyc; ext_reset = 1'b1;
        expect_ev(EV_RST_RISE, c + 1, "R7");
        expect_ev(EV_RDY_FALL, c + 1, "R7");
        tick(1); clr_reset_flag = 1'b1; tick(1); clr_reset_flag = 1'b0; tick(1);
        chk(reset_latched == 1'b1, "R8", "clear during reset ignored", reset_latched, 1);
        c = cyc; ext_reset = 1'b0;
        expect_ev(EV_RST_FALL, c + 1 + S, "R7");
        expect_ev(EV_CR_RISE, c + 2 + S, "R7");
        // R5 timeout and retry
        expect_ev(EV_CR_FALL, c + 2 + S + L, "R5");
        expect_ev(EV_TO_RISE, c + 2 + S + L, "R5");
        expect_ev(EV_CR_RISE, c + 3 + S + L, "R5");
        tick(S + L + 4);
        chk(cal_timeout == 1'b1, "R5", "timeout flag set", cal_timeout, 1);
        tick(4);
        // R6 clock loss aborts without timeout
        c = cyc; refclk_ok = 1'b0;
        expect_ev(EV_CR_FALL, c + 1, "R6");
        tick(4);
        chk(cal_req == 1'b0, "R6", "waiting after abort", cal_req, 0);
        c = cyc; refclk_ok = 1'b1;
        expect_ev(EV_CR_RISE, c + 1, "R6");
        tick(4);
        c = cyc; cal_done = 1'b1;
        expect_ev(EV_CR_FALL, c + 1, "R4");
        expect_ev(EV_RDY_RISE, c + 1, "R4");
        tick(1); cal_done = 1'b0; tick(2);
        chk(cal_timeout == 1'b1, "R9", "timeout flag sticky", cal_timeout, 1);

        // R1/R9 supply loss clears timeout flag
        c = cyc; supply_ok = 1'b0;
        expect_ev(EV_RST_RISE, c + 1, "R1");
        expect_ev(EV_RDY_FALL, c + 1, "R1");
        expect_ev(EV_TO_FALL, c + 1, "R9");
        tick(4);
        chk(sys_reset == 1'b1, "R1", "reset on supply loss", sys_reset, 1);

        // second power-up, timeout then strobe clear (R9)
        c = cyc; supply_ok = 1'b1;
        expect_ev(EV_RST_FALL, c + 1 + S, "R2");
        expect_ev(EV_CR_RISE, c + 2 + S, "R3");
        expect_ev(EV_CR_FALL, c + 2 + S + L, "R5");
        expect_ev(EV_TO_RISE, c + 2 + S + L, "R5");
        expect_ev(EV_CR_RISE, c + 3 + S + L, "R5");
        tick(S + L + 4);
        c = cyc; clr_timeout_flag = 1'b1;
        expect_ev(EV_TO_FALL, c + 1, "R9");
        tick(1); clr_timeout_flag = 1'b0; tick(2);
        c = cyc; cal_done = 1'b1;
        expect_ev(EV_CR_FALL, c + 1, "R4");
        expect_ev(EV_RDY_RISE, c + 1, "R4");
        tick(1); cal_done = 1'b0;
        tick(5);
        chk(sb.size() == 0, "R1..R10", "events left unmatched", sb.size(), 0);
        finish_run();
    end

endmodule